// File: doc/BRIEF.md
# Channel Configuration Command Controller

This block runs per-channel configuration commands for a multichannel analog input front end. A host programs it through a synchronous register port. It writes a channel selector, then a bank of parameter words, and then a control word. The top nibble of the control word is a command: clear a channel, fetch a channel's stored setup, store a new setup, or pick the AC mains frequency used for noise rejection. Each command runs in the single clock cycle after the control write. While it runs, `busy` is high. When it finishes, the command nibble returns to zero.

The block holds three things. The first is a parameter memory with one entry per channel. The second is a set of mode flags: pair, unipolar and square-root. The third is a packed status bitmap with one bit per configured channel, and it can span several 16-bit words. A differential pair takes up an even channel and the odd channel above it. Before any command takes effect, the block checks it against the pairing, polarity and mode-change rules. A command that breaks a rule leaves all state untouched and posts an error code. The acquisition path feeds converted samples in through a sample port. Clearing a channel zeroes its sample register.

Register map (7-bit word address): 1 = channel selector, 2 = control, 3 = error code (read only), 8 + w = status word w (read only), 16..16+NPAR-1 = parameters, 64 + c = sample of channel c (read only). Control word fields are: bits 15:12 = command, bit 9 = unipolar, bit 8 = pair, bit 7 = square-root.

Top module: `chan_cfg_sequencer`

## Requirements
- R1: After reset, `busy` = 0, `cfg_err` = 0, `line_is_60hz` = 1, and the control, selector, error, status, parameter and sample registers all read 0.
- R2: A host write to address 2 with a nonzero command nibble while `busy` = 0 raises `busy` for exactly the next cycle. After that cycle the control word reads back with bits 15:12 = 0.
- R3: Command 3 (store) with no error copies the parameter registers into the selected channel's memory. It records the mode bits and sets that channel's status bit. With bit 8 = 1 it also sets the status bit of channel sel+1 and marks both channels as a pair.
- R4: Command 2 (fetch) with no error loads the channel's stored parameters into addresses 16 upward. It also loads the stored unipolar, pair and square-root flags into control bits 9, 8 and 7.
- R5: Error code 1 (channel number) has top priority. It is raised when the selector is at or above NUM_CH. It is also raised when an odd selector is used for store with bit 8 = 1, or for any of commands 1 to 3 on a channel that belongs to a configured pair. The command then has no effect.
- R6: Error code 2 is raised when a store has bit 7 = 1 and bit 9 = 0, provided code 1 does not apply. The store then has no effect.
- R7: Error code 3 is raised when a store would change the single or pair mode of a channel whose status bit is still set. This covers the selected channel and, for a pair store, channel sel+1. It applies only if codes 1 and 2 do not, and the store then has no effect.
- R8: Command 1 (clear) with no error clears the status bit, the mode flags and the sample register of the channel. For a pair it clears both channels.
- R9: Channel c's status bit is bit c mod 16 of the status word at address 8 + c/16. Bits above NUM_CH read 0.
- R10: Command 4 sets `line_is_60hz` to 0 (50 Hz) and command 5 sets it to 1. Both clear the error code.
- R11: A command that passes its checks sets the error code to 0. Command codes 6 to 15 change nothing except that their nibble is cleared.
- R12: Host writes are ignored while `busy` = 1. Writes to the read-only addresses (error, status, samples) change nothing.
- R13: A sample-port strobe with a channel below NUM_CH loads that channel's sample register. A clear of the same channel in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 7 | Host word address (read and write) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data at `host_addr`, combinational |
| smp_valid | input | 1 | Sample strobe from the acquisition path |
| smp_ch | input | $clog2(NUM_CH) | Channel of the sample |
| smp_data | input | 16 | Sample value |
| busy | output | 1 | High during the command execution cycle |
| cfg_err | output | 2 | Current error code |
| line_is_60hz | output | 1 | Mains frequency choice, 1 = 60 Hz |

## Verification
The commands are tried on even, odd and out-of-range selectors. They cover single-ended stores, pair stores, and stores that set square-root without unipolar. This tells apart the three error codes and their priority, and shows whether a rejected command leaves the status map untouched. Fetches after the parameter bank has been overwritten show whether the read-back comes from the channel memory rather than the live registers. A store and a clear on channel 20 check that the bitmap is spread across status words. A control write followed at once by a selector write, and a write to a status word, check that ignored writes really leave no trace.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;
   localparam int CMD_LSB  = 12;
   localparam int SQRT_BIT = 7;
   localparam int PAIR_BIT = 8;
   localparam int UNI_BIT  = 9;

   localparam logic [6:0] A_CHSEL = 7'd1;
   localparam logic [6:0] A_CTRL  = 7'd2;
   localparam logic [6:0] A_ERR   = 7'd3;
   localparam logic [6:0] A_STAT  = 7'd8;
   localparam logic [6:0] A_PAR   = 7'd16;

   typedef enum logic [3:0] {
      OP_IDLE  = 4'd0,
      OP_CLEAR = 4'd1,
      OP_FETCH = 4'd2,
      OP_STORE = 4'd3,
      OP_HZ50  = 4'd4,
      OP_HZ60  = 4'd5
   } op_e;

   typedef enum logic [1:0] {
      E_NONE = 2'd0,
      E_CHAN = 2'd1,
      E_SQRT = 2'd2,
      E_MODE = 2'd3
   } err_e;

   // field order matches control bits 9:7
   typedef struct packed {
      logic uni;
      logic pair;
      logic sqrt;
   } mode_t;
endpackage

// File: rtl/chcfg_rules.sv
module chcfg_rules
   import chcfg_pkg::*;
#(
   parameter int NUM_CH = 24,
   localparam int CH_W = $clog2(NUM_CH)
)(
   input  logic [3:0]        op,
   input  logic [15:0]       chsel,
   input  mode_t             want,
   input  logic [NUM_CH-1:0] stat_vec,
   input  logic [NUM_CH-1:0] pair_vec,
   output err_e              verdict
);
   localparam logic [15:0] NCH16 = 16'(NUM_CH);

   logic            in_rng, member, is_store;
   logic [CH_W-1:0] idx, mate;

   always_comb begin
      in_rng   = chsel < NCH16;
      idx      = chsel[CH_W-1:0];
      mate     = idx | CH_W'(1);
      member   = in_rng && pair_vec[idx];
      is_store = (op == OP_STORE);
      verdict  = E_NONE;
      if (!in_rng)
         verdict = E_CHAN;
      else if (chsel[0] && (member || (is_store && want.pair)))
         verdict = E_CHAN;
      else if (is_store && want.sqrt && !want.uni)
         verdict = E_SQRT;
      else if (is_store &&
               ((stat_vec[idx] && (pair_vec[idx] != want.pair)) ||
                (want.pair && stat_vec[mate] && !pair_vec[mate])))
         verdict = E_MODE;
   end
endmodule

// File: rtl/chcfg_bank.sv
module chcfg_bank
   import chcfg_pkg::*;
#(
   parameter int NUM_CH = 24,
   parameter int NPAR   = 7,
   parameter int DW     = 16,
   localparam int CH_W  = $clog2(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_en,
   input  logic              store_en,
   input  logic [CH_W-1:0]   idx,
   input  logic              grp,
   input  logic [DW-1:0]     par_in [NPAR],
   input  mode_t             mode_in,
   input  logic              smp_valid,
   input  logic [CH_W-1:0]   smp_ch,
   input  logic [DW-1:0]     smp_data,
   output logic [DW-1:0]     par_out [NPAR],
   output mode_t             mode_out,
   output logic [NUM_CH-1:0] stat_vec,
   output logic [NUM_CH-1:0] pair_vec,
   output logic [DW-1:0]     data_vec [NUM_CH]
);
   logic [DW-1:0]   mem  [NUM_CH][NPAR];
   mode_t           mode [NUM_CH];
   logic [CH_W-1:0] mate;

   assign mate = idx | CH_W'(1);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = (idx == CH_W'(c)) || (grp && (mate == CH_W'(c)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_vec[c] <= 1'b0;
            mode[c]     <= '0;
            data_vec[c] <= '0;
            for (int p = 0; p < NPAR; p++) mem[c][p] <= '0;
         end else begin
            if (clear_en && hit) begin
               stat_vec[c] <= 1'b0;
               mode[c]     <= '0;
               data_vec[c] <= '0;
            end else begin
               if (store_en && hit) begin
                  stat_vec[c] <= 1'b1;
                  mode[c]     <= mode_in;
               end
               if (smp_valid && smp_ch == CH_W'(c))
                  data_vec[c] <= smp_data;
            end
            if (store_en && idx == CH_W'(c))
               for (int p = 0; p < NPAR; p++) mem[c][p] <= par_in[p];
         end
      end
      assign pair_vec[c] = mode[c].pair;
   end

   assign mode_out = mode[idx];
   for (genvar p = 0; p < NPAR; p++) begin : g_par
      assign par_out[p] = mem[idx][p];
   end
endmodule

// File: rtl/chan_cfg_sequencer.sv
module chan_cfg_sequencer
   import chcfg_pkg::*;
#(
   parameter int NUM_CH = 24,
   parameter int NPAR   = 7,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int NSW   = (NUM_CH + 15) / 16,
   localparam int PAD   = NSW * 16 - NUM_CH
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_wr,
   input  logic [6:0]      host_addr,
   input  logic [15:0]     host_wdata,
   output logic [15:0]     host_rdata,
   input  logic            smp_valid,
   input  logic [CH_W-1:0] smp_ch,
   input  logic [15:0]     smp_data,
   output logic            busy,
   output logic [1:0]      cfg_err,
   output logic            line_is_60hz
);
   if (NUM_CH < 2 || NUM_CH > 64 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("NUM_CH must be even and within 2..64");
   end
   if (NPAR < 1 || NPAR > 8) begin : g_bad_par
      $error("NPAR must be within 1..8");
   end

   localparam logic [5:0] NCH6 = 6'(NUM_CH);
   localparam logic [2:0] NPM1 = 3'(NPAR - 1);

   logic [15:0]       chsel_q, ctrl_q;
   logic [15:0]       par_q [NPAR];
   err_e              err_q;
   logic              busy_q, hz60_q;
   logic [3:0]        op;
   mode_t             want;
   err_e              verdict;
   logic              ok, clear_en, store_en, grp;
   logic [CH_W-1:0]   idx;
   logic [15:0]       par_out [NPAR];
   mode_t             mode_out;
   logic [NUM_CH-1:0] stat_vec, pair_vec;
   logic [15:0]       data_vec [NUM_CH];
   logic [NSW*16-1:0] stat_pad;
   logic [15:0]       stat_word [4];
   logic              smp_ok;

   assign op       = ctrl_q[CMD_LSB +: 4];
   assign want     = mode_t'(ctrl_q[UNI_BIT:SQRT_BIT]);
   assign idx      = chsel_q[CH_W-1:0];
   assign ok       = busy_q && (verdict == E_NONE);
   assign clear_en = ok && (op == OP_CLEAR);
   assign store_en = ok && (op == OP_STORE);
   assign grp      = (op == OP_STORE) ? want.pair : pair_vec[idx];
   assign smp_ok   = smp_valid && ({{(6-CH_W){1'b0}}, smp_ch} < NCH6);

   chcfg_rules #(.NUM_CH(NUM_CH)) u_rules (
      .op(op), .chsel(chsel_q), .want(want),
      .stat_vec(stat_vec), .pair_vec(pair_vec), .verdict(verdict)
   );

   chcfg_bank #(.NUM_CH(NUM_CH), .NPAR(NPAR), .DW(16)) u_bank (
      .clk(clk), .rst_n(rst_n), .clear_en(clear_en), .store_en(store_en),
      .idx(idx), .grp(grp), .par_in(par_q), .mode_in(want),
      .smp_valid(smp_ok), .smp_ch(smp_ch), .smp_data(smp_data),
      .par_out(par_out), .mode_out(mode_out),
      .stat_vec(stat_vec), .pair_vec(pair_vec), .data_vec(data_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chsel_q <= '0;
         ctrl_q  <= '0;
         err_q   <= E_NONE;
         busy_q  <= 1'b0;
         hz60_q  <= 1'b1;
         for (int p = 0; p < NPAR; p++) par_q[p] <= '0;
      end else if (busy_q) begin
         unique case (op)
            OP_CLEAR, OP_FETCH, OP_STORE: begin
               err_q <= verdict;
               if (verdict == E_NONE && op == OP_FETCH) begin
                  for (int p = 0; p < NPAR; p++) par_q[p] <= par_out[p];
                  ctrl_q[UNI_BIT:SQRT_BIT] <= mode_out;
               end
            end
            OP_HZ50: begin hz60_q <= 1'b0; err_q <= E_NONE; end
            OP_HZ60: begin hz60_q <= 1'b1; err_q <= E_NONE; end
            default: ;
         endcase
         ctrl_q[CMD_LSB +: 4] <= 4'd0;
         busy_q <= 1'b0;
      end else if (host_wr) begin
         if (host_addr == A_CHSEL) chsel_q <= host_wdata;
         if (host_addr == A_CTRL) begin
            ctrl_q <= host_wdata;
            busy_q <= (host_wdata[CMD_LSB +: 4] != 4'd0);
         end
         if (host_addr[6:3] == A_PAR[6:3] && host_addr[2:0] <= NPM1)
            par_q[host_addr[2:0]] <= host_wdata;
      end
   end

   if (PAD == 0) begin : g_nopad
      assign stat_pad = stat_vec;
   end else begin : g_pad
      assign stat_pad = {{PAD{1'b0}}, stat_vec};
   end
   for (genvar w = 0; w < 4; w++) begin : g_sw
      if (w < NSW) begin : g_live
         assign stat_word[w] = stat_pad[w*16 +: 16];
      end else begin : g_zero
         assign stat_word[w] = '0;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr[6]) begin
         if (host_addr[5:0] < NCH6) host_rdata = data_vec[host_addr[CH_W-1:0]];
      end else if (host_addr == A_CHSEL) host_rdata = chsel_q;
      else if (host_addr == A_CTRL)    host_rdata = ctrl_q;
      else if (host_addr == A_ERR)     host_rdata = {14'd0, err_q};
      else if (host_addr[6:2] == A_STAT[6:2]) host_rdata = stat_word[host_addr[1:0]];
      else if (host_addr[6:3] == A_PAR[6:3] && host_addr[2:0] <= NPM1)
         host_rdata = par_q[host_addr[2:0]];
   end

   assign busy         = busy_q;
   assign cfg_err      = err_q;
   assign line_is_60hz = hz60_q;
endmodule

// File: rtl/chan_cfg_sequencer_chk.sv
module chan_cfg_sequencer_chk #(
   parameter int NUM_CH = 24
)(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              host_wr,
   input logic [6:0]        host_addr,
   input logic [15:0]       host_wdata,
   input logic [3:0]        ctrl_cmd,
   input logic [NUM_CH-1:0] stat_vec,
   input logic              line_is_60hz,
   input logic [1:0]        cfg_err
);
   a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && host_wr && host_addr == 7'd2 && host_wdata[15:12] != 4'd0) |=> busy);
   a_r2_cmd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (ctrl_cmd == 4'd0));
   a_r8_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(stat_vec));
   a_r10_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(line_is_60hz));
   a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(cfg_err));
endmodule

bind chan_cfg_sequencer chan_cfg_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .host_wr(host_wr),
   .host_addr(host_addr), .host_wdata(host_wdata), .ctrl_cmd(ctrl_q[15:12]),
   .stat_vec(stat_vec), .line_is_60hz(line_is_60hz), .cfg_err(cfg_err)
);

// File: tb/chan_cfg_sequencer_tb_top.sv
module chan_cfg_sequencer_tb_top;
   localparam int NCH = 24;
   localparam int NP  = 7;

   logic        clk = 0, rst_n = 0;
   logic        host_wr = 0;
   logic [6:0]  host_addr = 0;
   logic [15:0] host_wdata = 0;
   logic [15:0] host_rdata;
   logic        smp_valid = 0;
   logic [4:0]  smp_ch = 0;
   logic [15:0] smp_data = 0;
   logic        busy, line_is_60hz;
   logic [1:0]  cfg_err;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   chan_cfg_sequencer #(.NUM_CH(NCH), .NPAR(NP)) dut_i (.*);

   // behavioural reference model
   int m_stat [NCH], m_pair [NCH], m_uni [NCH], m_sqrt [NCH];
   int m_cfg [NCH][NP], m_data [NCH], m_par [NP];
   int m_ctrl, m_chsel, m_err, m_busy, m_hz;

   task automatic m_exec();
      int cmd, ch, pb, sq, un, e, hi;
      cmd = m_ctrl / 4096; ch = m_chsel;
      pb = (m_ctrl >> 8) & 1; sq = (m_ctrl >> 7) & 1; un = (m_ctrl >> 9) & 1;
      if (cmd >= 1 && cmd <= 3) begin
         e = 0;
         if (ch >= NCH) e = 1;
         else if (ch % 2 == 1 && (m_pair[ch] != 0 || (cmd == 3 && pb != 0))) e = 1;
         else if (cmd == 3 && sq != 0 && un == 0) e = 2;
         else if (cmd == 3 && ((m_stat[ch] != 0 && m_pair[ch] != pb) ||
                  (pb != 0 && m_stat[ch+1] != 0 && m_pair[ch+1] == 0))) e = 3;
         m_err = e;
         if (e == 0) begin
            if (cmd == 1) begin
               hi = (m_pair[ch] != 0) ? ch + 1 : ch;
               for (int k = ch; k <= hi; k++) begin
                  m_stat[k] = 0; m_pair[k] = 0; m_uni[k] = 0; m_sqrt[k] = 0; m_data[k] = 0;
               end
            end else if (cmd == 2) begin
               for (int p = 0; p < NP; p++) m_par[p] = m_cfg[ch][p];
               m_ctrl = (m_ctrl & 'hFC7F) | (m_uni[ch] << 9) | (m_pair[ch] << 8) | (m_sqrt[ch] << 7);
            end else begin
               for (int p = 0; p < NP; p++) m_cfg[ch][p] = m_par[p];
               hi = (pb != 0) ? ch + 1 : ch;
               for (int k = ch; k <= hi; k++) begin
                  m_stat[k] = 1; m_pair[k] = pb; m_uni[k] = un; m_sqrt[k] = sq;
               end
            end
         end
      end else if (cmd == 4) begin m_hz = 0; m_err = 0; end
      else if (cmd == 5) begin m_hz = 1; m_err = 0; end
      m_ctrl = m_ctrl & 'h0FFF;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_stat[c] = 0; m_pair[c] = 0; m_uni[c] = 0; m_sqrt[c] = 0; m_data[c] = 0;
            for (int p = 0; p < NP; p++) m_cfg[c][p] = 0;
         end
         for (int p = 0; p < NP; p++) m_par[p] = 0;
         m_ctrl = 0; m_chsel = 0; m_err = 0; m_busy = 0; m_hz = 1;
      end else begin
         if (smp_valid && smp_ch < NCH) m_data[smp_ch] = smp_data;
         if (m_busy != 0) begin
            m_exec();
            m_busy = 0;
         end else if (host_wr) begin
            if (host_addr == 1) m_chsel = host_wdata;
            if (host_addr == 2) begin
               m_ctrl = host_wdata;
               m_busy = (host_wdata[15:12] != 0) ? 1 : 0;
            end
            if (host_addr >= 16 && host_addr < 16 + NP) m_par[host_addr-16] = host_wdata;
         end
      end
   end

   function automatic int m_read(int a);
      int v;
      v = 0;
      if (a >= 64) begin
         if (a - 64 < NCH) v = m_data[a-64];
      end else if (a == 1) v = m_chsel;
      else if (a == 2) v = m_ctrl;
      else if (a == 3) v = m_err;
      else if (a >= 8 && a < 12) begin
         for (int b = 0; b < 16; b++)
            if ((a - 8) * 16 + b < NCH && m_stat[(a-8)*16+b] != 0) v = v | (1 << b);
      end else if (a >= 16 && a < 16 + NP) v = m_par[a-16];
      return v;
   endfunction

   // comparison against the model on every clock
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         checks++;
         if (int'(busy) != m_busy) begin
            fails++; $display("FAIL R2 busy: actual %0d expected %0d", busy, m_busy);
         end
         if (int'(cfg_err) != m_err) begin
            fails++; $display("FAIL R11 cfg_err: actual %0d expected %0d", cfg_err, m_err);
         end
         if (int'(line_is_60hz) != m_hz) begin
            fails++; $display("FAIL R10 line: actual %0d expected %0d", line_is_60hz, m_hz);
         end
         if (int'(host_rdata) != m_read(int'(host_addr))) begin
            fails++; $display("FAIL R12 rdata@%0d: actual %h expected %h",
                              host_addr, host_rdata, m_read(int'(host_addr)));
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(string tag, logic [6:0] a, int exp);
      @(negedge clk);
      host_addr = a;
      #1;
      chk(tag, int'(host_rdata), exp);
   endtask

   task automatic wr(logic [6:0] a, logic [15:0] d);
      @(negedge clk);
      host_wr = 1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic cmd(logic [15:0] d);
      wr(7'd2, d);
      @(negedge clk);
   endtask

   task automatic setpar(int base);
      for (int i = 0; i < NP; i++) wr(7'(16 + i), 16'(base + i));
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 err", int'(cfg_err), 0);
      chk("R1 line", int'(line_is_60hz), 1);
      rd("R1 ctrl", 7'd2, 0);
      rd("R1 status", 7'd8, 0);
      rd("R1 sample", 7'd70, 0);
      // R3 single-ended store on channel 2
      setpar(100);
      wr(7'd1, 16'd2);
      wr(7'd2, 16'h3000);
      chk("R2 busy high", int'(busy), 1);
      @(negedge clk);
      chk("R2 busy low", int'(busy), 0);
      rd("R3 status", 7'd8, 'h0004);
      rd("R3 err", 7'd3, 0);
      // R4 fetch restores stored parameters
      setpar(0);
      cmd(16'h2000);
      rd("R4 param3", 7'd19, 103);
      rd("R2 cmd cleared", 7'd2, 'h0000);
      // R6 square root without unipolar
      wr(7'd1, 16'd3);
      cmd(16'h3080);
      chk("R6 err", int'(cfg_err), 2);
      rd("R6 status", 7'd8, 'h0004);
      // R5 odd pair store
      wr(7'd1, 16'd5);
      cmd(16'h3100);
      chk("R5 odd pair", int'(cfg_err), 1);
      // R7 mode change without clear
      wr(7'd1, 16'd2);
      cmd(16'h3100);
      chk("R7 err", int'(cfg_err), 3);
      // R8/R11 clear then valid command clears error
      cmd(16'h1000);
      chk("R11 err cleared", int'(cfg_err), 0);
      rd("R8 status", 7'd8, 0);
      // R3 pair store
      setpar(200);
      cmd(16'h3380);
      rd("R3 pair status", 7'd8, 'h000C);
      // R5 odd member of pair
      wr(7'd1, 16'd3);
      cmd(16'h2000);
      chk("R5 fetch odd", int'(cfg_err), 1);
      cmd(16'h1000);
      chk("R5 clear odd", int'(cfg_err), 1);
      rd("R5 status kept", 7'd8, 'h000C);
      // R4 mode flags read back
      wr(7'd1, 16'd2);
      setpar(0);
      cmd(16'h2000);
      rd("R4 ctrl flags", 7'd2, 'h0380);
      rd("R4 param0", 7'd16, 200);
      // R5 out of range
      wr(7'd1, 16'd30);
      cmd(16'h3000);
      chk("R5 range", int'(cfg_err), 1);
      // R11 unused code
      cmd(16'h6000);
      chk("R11 code6 err", int'(cfg_err), 1);
      rd("R11 code6 ctrl", 7'd2, 0);
      // R10 mains frequency
      cmd(16'h4000);
      chk("R10 50hz", int'(line_is_60hz), 0);
      chk("R10 err", int'(cfg_err), 0);
      cmd(16'h5000);
      chk("R10 60hz", int'(line_is_60hz), 1);
      // R13 sample port, R9 second status word
      @(negedge clk);
      smp_valid = 1; smp_ch = 5'd20; smp_data = 16'hBEEF;
      @(negedge clk);
      smp_valid = 0;
      rd("R13 sample", 7'd84, 'hBEEF);
      wr(7'd1, 16'd20);
      cmd(16'h3200);
      rd("R9 word1", 7'd9, 'h0010);
      rd("R9 word0", 7'd8, 'h000C);
      cmd(16'h1000);
      rd("R8 sample cleared", 7'd84, 0);
      rd("R8 word1", 7'd9, 0);
      // R12 writes during busy and to read-only words
      @(negedge clk);
      host_wr = 1; host_addr = 7'd2; host_wdata = 16'h4000;
      @(negedge clk);
      host_addr = 7'd1; host_wdata = 16'd7;
      @(negedge clk);
      host_wr = 0;
      rd("R12 chsel kept", 7'd1, 20);
      chk("R12 line", int'(line_is_60hz), 0);
      wr(7'd8, 16'hFFFF);
      rd("R12 status kept", 7'd8, 'h000C);
      // R8 clearing a pair clears both channels
      wr(7'd1, 16'd2);
      cmd(16'h1000);
      rd("R8 pair cleared", 7'd8, 0);
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule